// File: doc/BRIEF.md
# Mixed-Signedness Byte Dot-Product Accumulator

This block produces a single element of an integer matrix multiply-accumulate step. Each operation brings a 32-lane vector of bytes from a row of A and a 32-lane vector of bytes from a column of B. The block multiplies the vectors lane by lane and adds up the 32 products. That dot product is then either added to a signed 32-bit prior value or used on its own. Each operation names its own interpretation of A bytes and of B bytes (signed or unsigned), and chooses whether an out-of-range total is clamped or wrapped.

Operations enter through a valid/ready handshake. A three-stage pipeline returns each result after a fixed delay, and it can accept a new operation on every cycle. The result port has its own valid/ready pair. Back-pressure on the result stalls the pipeline without losing data.

Top module: `mixdot_acc`

## Requirements
- R1: Lane i of `vecA` occupies bits [8i+7:8i]. It is read as two's complement when `aSigned` is 1 and as unsigned when it is 0.
- R2: Lane i of `vecB` occupies bits [8i+7:8i]. It is read as two's complement when `bSigned` is 1 and as unsigned when it is 0, independently of `aSigned`. All four pairings give the exact sum of the 32 products.
- R3: When `accEn` is 0, the result is the dot product alone, and `accIn` has no effect on the result.
- R4: When `accEn` is 1, the result is the dot product plus `accIn`, with `accIn` taken as signed 32-bit.
- R5: When `satEn` is 1, a total above 2^31-1 yields 0x7FFFFFFF and a total below -2^31 yields 0x80000000.
- R6: When `satEn` is 0, the result is the total modulo 2^32.
- R7: An operation accepted at the end of cycle c (`inValid` and `inReady` both high) shows its result with `outValid` high in cycle c+3, provided `outReady` stays high.
- R8: While `outReady` is high, `inReady` is high, so one operation per cycle is accepted.
- R9: While `outValid` is high and `outReady` is low, `outValid` and `outData` stay unchanged in the next cycle, and no result is lost or duplicated.
- R10: Asynchronous active-low reset empties the pipeline: `outValid` is 0 and `inReady` is 1 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operation offered |
| inReady | output | 1 | Operation can be taken this cycle |
| vecA | input | 256 | 32 A bytes, lane i at [8i+7:8i] |
| vecB | input | 256 | 32 B bytes, lane i at [8i+7:8i] |
| aSigned | input | 1 | 1: A bytes signed, 0: unsigned |
| bSigned | input | 1 | 1: B bytes signed, 0: unsigned |
| accEn | input | 1 | 1: add accIn, 0: ignore it |
| satEn | input | 1 | 1: clamp to int32, 0: wrap |
| accIn | input | 32 | Prior signed accumulator value |
| outValid | output | 1 | Result available |
| outReady | input | 1 | Result consumer can take it |
| outData | output | 32 | Signed 32-bit result |

## Verification
Some properties are checked on every cycle:
- ready is high whenever the output is ready;
- a stalled result stays in place;
- each stage hands its valid on when the next stage advances;
- reset empties the pipeline;
- with accumulation off, the result equals the stage-two sum;
- with saturation on, two same-sign operands never produce a result of the opposite sign.

The bench scenarios are needed for the arithmetic itself, which a reference model checks against every result. These cover:
- all four signedness pairings at extreme byte values;
- overflow past both int32 bounds, clamped and wrapped;
- the exact three-cycle delay;
- ordering and loss under random back-pressure.

// File: rtl/mixdot_pkg.sv
package mixdot_pkg;
  parameter int unsigned LANES  = 32;
  parameter int unsigned ELEM_W = 8;
  parameter int unsigned ACC_W  = 32;
  parameter int unsigned SUM_W  = 40;
  localparam int unsigned EXT_W  = ELEM_W + 1;
  localparam int unsigned PROD_W = 2 * EXT_W;
  localparam int unsigned VEC_W  = LANES * ELEM_W;

  // load strobes from control to datapath, one per pipeline stage
  typedef struct packed {
    logic ld1;
    logic ld2;
    logic ld3;
  } stage_strobe_t;
endpackage

// File: rtl/mixdot_ctrl.sv
module mixdot_ctrl
  import mixdot_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  input  logic          outReady,
  output logic          inReady,
  output logic          outValid,
  output stage_strobe_t strobe
);
  localparam int unsigned NSTG = 3;

  logic [NSTG-1:0] vld;
  logic [NSTG-1:0] adv;
  logic [NSTG-1:0] feed;

  // a stage may load when empty or when the stage after it moves on
  always_comb begin
    adv[NSTG-1] = !vld[NSTG-1] || outReady;
    for (int s = NSTG - 2; s >= 0; s--) adv[s] = !vld[s] || adv[s+1];
  end

  always_comb begin
    feed[0] = inValid;
    for (int s = 1; s < NSTG; s++) feed[s] = vld[s-1];
  end

  generate
    for (genvar s = 0; s < NSTG; s++) begin : g_stage
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)       vld[s] <= 1'b0;
        else if (adv[s]) vld[s] <= feed[s];
      end
    end
  endgenerate

  assign inReady    = adv[0];
  assign outValid   = vld[NSTG-1];
  assign strobe.ld1 = adv[0] && feed[0];
  assign strobe.ld2 = adv[1] && feed[1];
  assign strobe.ld3 = adv[2] && feed[2];

  p_ready_r8: assert property (@(posedge clk) disable iff (!rstN)
    outReady |-> inReady);

  p_stall_r9: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> outValid);

  p_flow_r7: assert property (@(posedge clk) disable iff (!rstN)
    (vld[0] && adv[1]) |=> vld[1]);

  p_reset_r10: assert property (@(posedge clk)
    !rstN |=> !outValid);
endmodule

// File: rtl/mixdot_dp.sv
module mixdot_dp
  import mixdot_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  stage_strobe_t       strobe,
  input  logic [VEC_W-1:0]    vecA,
  input  logic [VEC_W-1:0]    vecB,
  input  logic                aSigned,
  input  logic                bSigned,
  input  logic                accEn,
  input  logic                satEn,
  input  logic [ACC_W-1:0]    accIn,
  output logic [ACC_W-1:0]    result
);
  localparam logic signed [SUM_W-1:0] hiLim =
    {{(SUM_W-ACC_W+1){1'b0}}, {(ACC_W-1){1'b1}}};
  localparam logic signed [SUM_W-1:0] loLim = ~hiLim;

  // stage 1: per-lane products of 9-bit extended bytes
  logic signed [PROD_W-1:0] prodNext [LANES];
  logic signed [PROD_W-1:0] prod1    [LANES];
  logic signed [ACC_W-1:0]  acc1, acc2;
  logic                     en1, sat1, en2, sat2;

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [ELEM_W-1:0]       rawA, rawB;
      logic signed [EXT_W-1:0] extA, extB;
      assign rawA = vecA[i*ELEM_W +: ELEM_W];
      assign rawB = vecB[i*ELEM_W +: ELEM_W];
      assign extA = {aSigned & rawA[ELEM_W-1], rawA};
      assign extB = {bSigned & rawB[ELEM_W-1], rawB};
      assign prodNext[i] = extA * extB;

      always_ff @(posedge clk) begin
        if (strobe.ld1) prod1[i] <= prodNext[i];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (strobe.ld1) begin
      acc1 <= accIn;
      en1  <= accEn;
      sat1 <= satEn;
    end
  end

  // stage 2: reduce the lanes in a wide adder
  logic signed [SUM_W-1:0] sumNext, sum2;
  always_comb begin
    sumNext = '0;
    for (int i = 0; i < LANES; i++) sumNext = sumNext + SUM_W'(prod1[i]);
  end

  always_ff @(posedge clk) begin
    if (strobe.ld2) begin
      sum2 <= sumNext;
      acc2 <= acc1;
      en2  <= en1;
      sat2 <= sat1;
    end
  end

  // stage 3: merge accumulator, then clamp or wrap
  logic signed [SUM_W-1:0] total;
  logic [ACC_W-1:0]        finalNext;
  always_comb begin
    total = sum2 + (en2 ? SUM_W'(acc2) : '0);
    if (sat2 && total > hiLim)      finalNext = hiLim[ACC_W-1:0];
    else if (sat2 && total < loLim) finalNext = loLim[ACC_W-1:0];
    else                            finalNext = total[ACC_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (strobe.ld3) result <= finalNext;
  end

  p_ignore_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.ld3 && !en2) |=> result == $past(sum2[ACC_W-1:0]));

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.ld3 && sat2 && en2 && !acc2[ACC_W-1] && !sum2[SUM_W-1]) |=> !result[ACC_W-1]);

  p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.ld3 && sat2 && en2 && acc2[ACC_W-1] && sum2[SUM_W-1]) |=> result[ACC_W-1]);
endmodule

// File: rtl/mixdot_acc.sv
module mixdot_acc
  import mixdot_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  output logic             inReady,
  input  logic [VEC_W-1:0] vecA,
  input  logic [VEC_W-1:0] vecB,
  input  logic             aSigned,
  input  logic             bSigned,
  input  logic             accEn,
  input  logic             satEn,
  input  logic [ACC_W-1:0] accIn,
  output logic             outValid,
  input  logic             outReady,
  output logic [ACC_W-1:0] outData
);
  stage_strobe_t strobe;

  mixdot_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .outReady(outReady),
    .inReady(inReady), .outValid(outValid), .strobe(strobe)
  );

  mixdot_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .vecA(vecA), .vecB(vecB),
    .aSigned(aSigned), .bSigned(bSigned), .accEn(accEn), .satEn(satEn),
    .accIn(accIn), .result(outData)
  );

  p_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> $stable(outData));
endmodule

// File: tb/mixdot_acc_tb.sv
module mixdot_acc_tb;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0, inReady;
  logic [255:0] vecA = '0, vecB = '0;
  logic         aSigned = 1'b0, bSigned = 1'b0, accEn = 1'b0, satEn = 1'b0;
  logic [31:0]  accIn = '0;
  logic         outValid, outReady = 1'b1;
  logic [31:0]  outData;

  always #2 clk = ~clk;  // 250 MHz

  mixdot_acc u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .vecA(vecA), .vecB(vecB), .aSigned(aSigned), .bSigned(bSigned),
    .accEn(accEn), .satEn(satEn), .accIn(accIn), .outValid(outValid),
    .outReady(outReady), .outData(outData)
  );

  int checks = 0, fails = 0, cyc = 0;
  bit latMode = 1'b0, done = 1'b0;
  bit holdPending = 1'b0;
  logic [31:0] holdData;
  logic [31:0] expQ[$];
  string       tagQ[$];
  int          cycQ[$];

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] refRes(logic [255:0] a, logic [255:0] b, bit as, bit bs,
                                         bit en, bit sat, logic [31:0] acc);
    longint s = 0;
    for (int i = 0; i < 32; i++) begin
      longint ea = as ? longint'($signed(a[8*i +: 8])) : longint'(a[8*i +: 8]);
      longint eb = bs ? longint'($signed(b[8*i +: 8])) : longint'(b[8*i +: 8]);
      s += ea * eb;
    end
    if (en) s += longint'($signed(acc));
    if (sat) begin
      if (s > 64'sd2147483647) s = 64'sd2147483647;
      if (s < -64'sd2147483648) s = -64'sd2147483648;
    end
    return s[31:0];
  endfunction

  // one cycle: drive at negedge, then observe the handshakes due at the next edge
  task automatic cycleDo(input bit iv, input bit ordy, input logic [255:0] a, input logic [255:0] b,
                         input bit as, input bit bs, input bit en, input bit sat,
                         input logic [31:0] acc, input string tag);
    @(negedge clk);
    cyc++;
    if (holdPending) begin
      check(outValid == 1'b1, "R9 valid held", {31'b0, outValid}, 32'd1);
      check(outData == holdData, "R9 data held", outData, holdData);
    end
    inValid = iv; outReady = ordy; vecA = a; vecB = b;
    aSigned = as; bSigned = bs; accEn = en; satEn = sat; accIn = acc;
    #1;
    if (ordy) check(inReady == 1'b1, "R8 ready with outReady", {31'b0, inReady}, 32'd1);
    if (outValid && outReady) begin
      if (expQ.size() == 0) check(1'b0, "R9 unexpected result", outData, 32'hx);
      else begin
        logic [31:0] e = expQ.pop_front();
        string t = tagQ.pop_front();
        int c = cycQ.pop_front();
        check(outData == e, t, outData, e);
        if (latMode) check(cyc - c == 3, "R7 latency", cyc - c, 32'd3);
      end
    end
    if (iv && inReady) begin
      expQ.push_back(refRes(a, b, as, bs, en, sat, acc));
      tagQ.push_back(tag);
      cycQ.push_back(cyc);
    end
    holdPending = outValid && !outReady;
    holdData = outData;
  endtask

  function automatic logic [255:0] fill(logic [7:0] v);
    return {32{v}};
  endfunction

  function automatic logic [255:0] rndVec();
    logic [255:0] v;
    for (int w = 0; w < 8; w++) v[32*w +: 32] = $urandom();
    return v;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check(outValid == 1'b0, "R10 outValid after reset", {31'b0, outValid}, 32'd0);
    check(inReady == 1'b1, "R10 inReady after reset", {31'b0, inReady}, 32'd1);
    rstN = 1'b1;
    @(negedge clk);
    check(outValid == 1'b0, "R10 idle after release", {31'b0, outValid}, 32'd0);

    latMode = 1'b1;
    cycleDo(1, 1, fill(8'h80), fill(8'h80), 1, 1, 0, 0, 32'h12345678, "R1 R3 s*s ignore acc");
    cycleDo(1, 1, fill(8'hFF), fill(8'hFF), 0, 0, 0, 0, 32'hDEADBEEF, "R2 u*u");
    cycleDo(1, 1, fill(8'h80), fill(8'hFF), 1, 0, 0, 0, 32'h0, "R1 s*u");
    cycleDo(1, 1, fill(8'hFF), fill(8'hFF), 0, 1, 0, 0, 32'h0, "R2 u*s");
    cycleDo(1, 1, fill(8'h03), fill(8'hFE), 1, 1, 1, 0, 32'd1000, "R4 accumulate");
    cycleDo(1, 1, fill(8'hFF), fill(8'hFF), 0, 0, 1, 1, 32'h7FFFFFF0, "R5 clamp high");
    cycleDo(1, 1, fill(8'hFF), fill(8'hFF), 0, 0, 1, 0, 32'h7FFFFFF0, "R6 wrap high");
    cycleDo(1, 1, fill(8'h80), fill(8'hFF), 1, 0, 1, 1, 32'h80000000, "R5 clamp low");
    cycleDo(1, 1, fill(8'h80), fill(8'hFF), 1, 0, 1, 0, 32'h80000000, "R6 wrap low");
    cycleDo(1, 1, fill(8'h80), fill(8'h80), 1, 1, 0, 1, 32'h7FFFFFFF, "R3 overwrite no sat trip");
    for (int k = 0; k < 6; k++) cycleDo(0, 1, '0, '0, 0, 0, 0, 0, 32'h0, "idle");
    latMode = 1'b0;

    for (int k = 0; k < 400; k++) begin
      bit en = $urandom_range(0, 1);
      bit sat = $urandom_range(0, 1);
      string tg = en ? (sat ? "R5 random acc sat" : "R6 random acc wrap") : "R3 random overwrite";
      cycleDo($urandom_range(0, 3) != 0, $urandom_range(0, 2) != 0, rndVec(), rndVec(),
              $urandom_range(0, 1), $urandom_range(0, 1), en, sat, $urandom(), tg);
    end
    for (int k = 0; k < 12; k++) cycleDo(0, 1, '0, '0, 0, 0, 0, 0, 32'h0, "drain");
    check(expQ.size() == 0, "R9 all results delivered", expQ.size(), 32'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule